// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible control and status register set of a multi-channel DMA controller. It serves up to sixteen channels and is built for twelve by default. Software sets each channel's transfer mode and transfer direction and its interrupt enable through a plain register port with an address, write data, a write strobe and combinational read data. The bank passes these settings straight to the channel engines. The engines return a completion pulse, an error pulse and a live 2-bit activity state. The bank turns the pulses into sticky flags that software clears by writing ones. It combines the enabled flags into a single interrupt line.

Each channel's settings sit in a 4-bit lane of a mode word. Channels 0 to 7 use the lower word and channels 8 and up use the upper word. A write to a mode word changes every lane except those that carry the reserved mode code 3. Software can therefore retarget one channel without reading the word first, so two agents that each own different channels cannot race each other.

The read/write port is plain control access with no handshake. A write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle.

Top module: `dma_csr_bank`

## Requirements
- R1: While reset is asserted and after it releases, every mode, direction and enable output is 0, every flag is clear, `irq_out` is 0, and each defined word reads 0 when all channel states are 0.
- R2: A write to byte offset 0x00 sets channel c (c < 8) from bits [4c+3:4c]. Bits [1:0] carry the mode: 0 off, 1 descriptor chain, 2 single block. Bit 2 carries the direction: 1 memory to device, 0 device to memory. Bit 3 is ignored. The outputs change at the write edge, and the lane reads back as {0, direction, mode}.
- R3: A lane written with mode code 3 keeps that channel's stored mode and direction. The other lanes in the same write still update.
- R4: Offset 0x0C is the upper mode word for channels 8 and up. Channel c uses lane c-8, so channel 8 sits at bits [3:0]. The lane layout and the code 3 rule are the same as in R2 and R3.
- R5: Offset 0x08 holds the interrupt enables. Channel c < 8 uses bit c and channel c >= 8 uses bit c+8. All other bits read 0.
- R6: A completion pulse sets the channel's interrupt flag at the next edge. An error pulse sets both its interrupt flag and its error flag.
- R7: In a status word, writing 1 to a flag bit clears that flag and writing 0 leaves it unchanged. When a set pulse and a clearing write hit the same edge, the flag stays set.
- R8: Status word 0x10 covers channels 0 to 7 and status word 0x18 covers channels 8 and up, with j as the channel's lane. Bit j is the interrupt flag, bit j+8 is the error flag, and bits [17+2j:16+2j] show the live state input in the same cycle (0 idle, 1 fetching descriptor, 2 waiting, 3 moving data).
- R9: `irq_out` is high exactly when some channel has both its interrupt flag and its enable set.
- R10: Offsets 0x04, 0x14 and 0x1C, and any address with bits [1:0] not zero, read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Per-channel error pulse |
| ch_state | input | 2*NUM_CH | Per-channel live activity state |
| ch_mode | output | 2*NUM_CH | Per-channel mode, 2 bits each |
| ch_dir | output | NUM_CH | Per-channel direction, 1 = memory to device |
| ch_irq_en | output | NUM_CH | Per-channel interrupt enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with the default of twelve channels. With twelve channels the upper mode word, the shifted enable positions of channels 8 to 11 and the upper status word are all in use, alongside the full lower words. A behavioural model tracks every mode, flag and enable and is compared on every cycle. This covers mixed code 3 lanes, same-edge set and clear on one flag, and random traffic that includes reserved and unaligned addresses.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int LANES      = 8;   // channels per word
  localparam int FIELD_W    = 4;   // mode lane width
  localparam int FLAG_GAP   = 8;   // error flags sit this far above irq flags
  localparam int STATE_BASE = 16;  // first live-state bit in a status word
  localparam int MAX_CH     = 16;

  // word index = byte address [4:2]
  localparam logic [2:0] IDX_MODE_LO = 3'd0;
  localparam logic [2:0] IDX_IEN     = 3'd2;
  localparam logic [2:0] IDX_MODE_HI = 3'd3;
  localparam logic [2:0] IDX_STAT_LO = 3'd4;
  localparam logic [2:0] IDX_STAT_HI = 3'd6;

  typedef enum logic [1:0] {
    XFER_OFF    = 2'd0,
    XFER_CHAIN  = 2'd1,
    XFER_SINGLE = 2'd2,
    XFER_KEEP   = 2'd3
  } xfer_mode_e;

  // bit position of a channel's interrupt enable
  function automatic int en_pos(input int c);
    return (c / LANES) * 2 * LANES + (c % LANES);
  endfunction

endpackage

// File: rtl/dma_csr_lane_cfg.sv
module dma_csr_lane_cfg
  import dma_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                field_wr,
  input  logic [FIELD_W-1:0]  field,
  input  logic                en_wr,
  input  logic                en_val,
  output logic [1:0]          mode,
  output logic                dir,
  output logic                irq_en
);

  xfer_mode_e mode_q;
  logic       dir_q;
  logic       en_q;
  xfer_mode_e req_mode;

  assign req_mode = xfer_mode_e'(field[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XFER_OFF;
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (field_wr && req_mode != XFER_KEEP) begin
        mode_q <= req_mode;
        dir_q  <= field[2];
      end
      if (en_wr) en_q <= en_val;
    end
  end

  assign mode   = mode_q;
  assign dir    = dir_q;
  assign irq_en = en_q;

endmodule

// File: rtl/dma_csr_lane_flags.sv
module dma_csr_lane_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic err,
  input  logic clr_irq,
  input  logic clr_err,
  output logic irq_flag,
  output logic err_flag
);

  logic irq_q, err_q;

  // a set pulse wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= (irq_q & ~clr_irq) | done | err;
      err_q <= (err_q & ~clr_err) | err;
    end
  end

  assign irq_flag = irq_q;
  assign err_flag = err_q;

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_we,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_CH-1:0]   ch_done,
  input  logic [NUM_CH-1:0]   ch_err,
  input  logic [2*NUM_CH-1:0] ch_state,
  output logic [2*NUM_CH-1:0] ch_mode,
  output logic [NUM_CH-1:0]   ch_dir,
  output logic [NUM_CH-1:0]   ch_irq_en,
  output logic                irq_out
);

  localparam int HAS_HI = (NUM_CH > LANES) ? 1 : 0;

  logic       word_ok;
  logic [2:0] idx;
  logic       wr_mode_lo, wr_mode_hi, wr_ien, wr_stat_lo, wr_stat_hi;
  logic [NUM_CH-1:0] flag_irq, flag_err;

  assign word_ok    = (reg_addr[1:0] == 2'b00);
  assign idx        = reg_addr[4:2];
  assign wr_mode_lo = reg_we && word_ok && idx == IDX_MODE_LO;
  assign wr_mode_hi = reg_we && word_ok && idx == IDX_MODE_HI && HAS_HI != 0;
  assign wr_ien     = reg_we && word_ok && idx == IDX_IEN;
  assign wr_stat_lo = reg_we && word_ok && idx == IDX_STAT_LO;
  assign wr_stat_hi = reg_we && word_ok && idx == IDX_STAT_HI && HAS_HI != 0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    localparam int  LANE  = c % LANES;
    localparam bit  UPPER = (c >= LANES);
    logic field_wr, clr_irq, clr_err, stat_wr;

    assign field_wr = UPPER ? wr_mode_hi : wr_mode_lo;
    assign stat_wr  = UPPER ? wr_stat_hi : wr_stat_lo;
    assign clr_irq  = stat_wr & reg_wdata[LANE];
    assign clr_err  = stat_wr & reg_wdata[LANE + FLAG_GAP];

    dma_csr_lane_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .field_wr (field_wr),
      .field    (reg_wdata[FIELD_W*LANE +: FIELD_W]),
      .en_wr    (wr_ien),
      .en_val   (reg_wdata[en_pos(c)]),
      .mode     (ch_mode[2*c +: 2]),
      .dir      (ch_dir[c]),
      .irq_en   (ch_irq_en[c])
    );

    dma_csr_lane_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (ch_done[c]),
      .err      (ch_err[c]),
      .clr_irq  (clr_irq),
      .clr_err  (clr_err),
      .irq_flag (flag_irq[c]),
      .err_flag (flag_err[c])
    );
  end

  assign irq_out = |(flag_irq & ch_irq_en);

  // readback words
  logic [DATA_W-1:0] w_mode_lo, w_mode_hi, w_ien, w_stat_lo, w_stat_hi;

  always_comb begin
    w_mode_lo = '0;
    w_mode_hi = '0;
    w_ien     = '0;
    w_stat_lo = '0;
    w_stat_hi = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      w_ien[en_pos(c)] = ch_irq_en[c];
      if (c >= LANES) begin
        w_mode_hi[FIELD_W*(c % LANES) +: FIELD_W] = {1'b0, ch_dir[c], ch_mode[2*c +: 2]};
        w_stat_hi[c % LANES]                      = flag_irq[c];
        w_stat_hi[(c % LANES) + FLAG_GAP]         = flag_err[c];
        w_stat_hi[STATE_BASE + 2*(c % LANES) +: 2] = ch_state[2*c +: 2];
      end else begin
        w_mode_lo[FIELD_W*(c % LANES) +: FIELD_W] = {1'b0, ch_dir[c], ch_mode[2*c +: 2]};
        w_stat_lo[c % LANES]                      = flag_irq[c];
        w_stat_lo[(c % LANES) + FLAG_GAP]         = flag_err[c];
        w_stat_lo[STATE_BASE + 2*(c % LANES) +: 2] = ch_state[2*c +: 2];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (word_ok) begin
      case (idx)
        IDX_MODE_LO: reg_rdata = w_mode_lo;
        IDX_IEN:     reg_rdata = w_ien;
        IDX_MODE_HI: reg_rdata = w_mode_hi;
        IDX_STAT_LO: reg_rdata = w_stat_lo;
        IDX_STAT_HI: reg_rdata = w_stat_hi;
        default:     reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic                reg_we,
  input logic [NUM_CH-1:0]   ch_done,
  input logic [NUM_CH-1:0]   ch_err,
  input logic [2*NUM_CH-1:0] ch_mode,
  input logic [NUM_CH-1:0]   ch_dir,
  input logic [NUM_CH-1:0]   ch_irq_en,
  input logic                irq_out,
  input logic [NUM_CH-1:0]   flag_err
);

  assert_lane0_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h00 && reg_wdata[1:0] == 2'd1)
    |=> (ch_mode[1:0] == 2'd1 && ch_dir[0] == $past(reg_wdata[2])));

  assert_keep_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h00 && reg_wdata[1:0] == 2'd3)
    |=> ($stable(ch_mode[1:0]) && $stable(ch_dir[0])));

  assert_err_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ch_err[0] |=> flag_err[0]);

  assert_enabled_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && (ch_done & ch_irq_en) != '0) |=> irq_out);

  assert_reserved_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h1C)
    |=> ($stable(ch_mode) && $stable(ch_dir) && $stable(ch_irq_en)));

endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .ch_done   (ch_done),
  .ch_err    (ch_err),
  .ch_mode   (ch_mode),
  .ch_dir    (ch_dir),
  .ch_irq_en (ch_irq_en),
  .irq_out   (irq_out),
  .flag_err  (flag_err)
);

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;

  localparam int NCH = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic            reg_we = 1'b0;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  ch_done = '0;
  logic [NCH-1:0]  ch_err = '0;
  logic [2*NCH-1:0] ch_state = '0;
  logic [2*NCH-1:0] ch_mode;
  logic [NCH-1:0]  ch_dir;
  logic [NCH-1:0]  ch_irq_en;
  logic            irq_out;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  dma_csr_bank #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ch_done(ch_done), .ch_err(ch_err),
    .ch_state(ch_state), .ch_mode(ch_mode), .ch_dir(ch_dir),
    .ch_irq_en(ch_irq_en), .irq_out(irq_out)
  );

  // behavioural reference model
  int m_mode[NCH];
  bit m_dir[NCH];
  bit m_en[NCH];
  bit m_irq[NCH];
  bit m_err[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_mode[c] = 0; m_dir[c] = 0; m_en[c] = 0; m_irq[c] = 0; m_err[c] = 0;
      end
    end else begin
      if (reg_we && reg_addr[1:0] == 2'b00) begin
        for (int c = 0; c < NCH; c++) begin
          int lane;
          int f;
          lane = c % 8;
          f = int'((reg_wdata >> (4*lane)) & 32'hF);
          if ((reg_addr == 5'h00 && c < 8) || (reg_addr == 5'h0C && c >= 8)) begin
            if ((f & 3) != 3) begin
              m_mode[c] = f & 3;
              m_dir[c]  = f[2];
            end
          end
          if (reg_addr == 5'h08) m_en[c] = reg_wdata[c < 8 ? c : c + 8];
          if ((reg_addr == 5'h10 && c < 8) || (reg_addr == 5'h18 && c >= 8)) begin
            if (reg_wdata[lane])     m_irq[c] = 0;
            if (reg_wdata[lane + 8]) m_err[c] = 0;
          end
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (ch_done[c] || ch_err[c]) m_irq[c] = 1;
        if (ch_err[c]) m_err[c] = 1;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    if (a[1:0] != 2'b00) return r;
    for (int c = 0; c < NCH; c++) begin
      int lane;
      bit up;
      lane = c % 8;
      up = (c >= 8);
      case (a)
        5'h00: if (!up) r[4*lane +: 4] = 4'(m_mode[c] + 4*int'(m_dir[c]));
        5'h0C: if (up)  r[4*lane +: 4] = 4'(m_mode[c] + 4*int'(m_dir[c]));
        5'h08: r[c < 8 ? c : c + 8] = m_en[c];
        5'h10: if (!up) begin
          r[lane] = m_irq[c]; r[lane + 8] = m_err[c];
          r[16 + 2*lane +: 2] = ch_state[2*c +: 2];
        end
        5'h18: if (up) begin
          r[lane] = m_irq[c]; r[lane + 8] = m_err[c];
          r[16 + 2*lane +: 2] = ch_state[2*c +: 2];
        end
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    case (a)
      5'h00:   return "R2 mode word lo readback";
      5'h0C:   return "R4 mode word hi readback";
      5'h08:   return "R5 enable readback";
      5'h10, 5'h18: return "R6 R7 R8 status readback";
      default: return "R10 unused offset reads zero";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      logic [31:0] em, ed, ee;
      bit ei;
      em = '0; ed = '0; ee = '0; ei = 0;
      for (int c = 0; c < NCH; c++) begin
        em[2*c +: 2] = 2'(m_mode[c]);
        ed[c] = m_dir[c];
        ee[c] = m_en[c];
        if (m_irq[c] && m_en[c]) ei = 1;
      end
      chk(32'(ch_mode), em, "R2 R3 R4 mode outputs");
      chk(32'(ch_dir), ed, "R2 R4 direction outputs");
      chk(32'(ch_irq_en), ee, "R5 enable outputs");
      chk(32'(irq_out), 32'(ei), "R9 combined interrupt");
      chk(reg_rdata, exp_rd(reg_addr), rd_tag(reg_addr));
    end
  end

  // one edge of stimulus; returns 2 ns after that edge with pulses cleared
  task automatic step(input logic [4:0] a, input logic [31:0] d, input bit we,
                      input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_we = we; ch_done = dn; ch_err = er;
    @(posedge clk); #2;
    reg_we = 1'b0; ch_done = '0; ch_err = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [23:0] sv_mode;
    logic [11:0] sv_dir, sv_en;
    // R1: reset state
    repeat (3) @(posedge clk);
    #3;
    chk(32'(ch_mode), 0, "R1 mode in reset");
    chk(32'(ch_dir), 0, "R1 dir in reset");
    chk(32'(ch_irq_en), 0, "R1 enable in reset");
    chk(32'(irq_out), 0, "R1 irq in reset");
    @(posedge clk); #2 rst_n = 1'b1;
    step(5'h00, 0, 0, '0, '0); chk(reg_rdata, 0, "R1 mode lo after reset");
    step(5'h08, 0, 0, '0, '0); chk(reg_rdata, 0, "R1 enables after reset");
    step(5'h10, 0, 0, '0, '0); chk(reg_rdata, 0, "R1 status lo after reset");
    step(5'h18, 0, 0, '0, '0); chk(reg_rdata, 0, "R1 status hi after reset");

    // R2: lane fields
    step(5'h00, 32'h0000_0425, 1, '0, '0);
    chk(32'(ch_mode[1:0]), 1, "R2 ch0 chain mode");
    chk(32'(ch_dir[0]), 1, "R2 ch0 mem-to-dev");
    chk(32'(ch_mode[3:2]), 2, "R2 ch1 single mode");
    chk(32'(ch_dir[2]), 1, "R2 ch2 direction");

    // R3: code 3 keeps lane, others update
    step(5'h00, 32'h0000_0037, 1, '0, '0);
    chk(32'(ch_mode[1:0]), 1, "R3 ch0 kept mode");
    chk(32'(ch_dir[0]), 1, "R3 ch0 kept dir");
    chk(32'(ch_mode[3:2]), 2, "R3 ch1 kept mode");
    chk(32'(ch_dir[2]), 0, "R3 ch2 updated");

    // R4: upper word
    step(5'h0C, 32'h0000_0306, 1, '0, '0);
    chk(32'(ch_mode[17:16]), 2, "R4 ch8 mode");
    chk(32'(ch_dir[8]), 1, "R4 ch8 dir");
    chk(32'(ch_mode[21:20]), 0, "R4 ch10 code3 kept");
    chk(32'(ch_mode[1:0]), 1, "R4 lower word untouched");

    // R5: enables
    step(5'h08, 32'hFFFF_FFFF, 1, '0, '0);
    chk(32'(ch_irq_en), 32'hFFF, "R5 all enables");
    step(5'h08, 0, 0, '0, '0);
    chk(reg_rdata, 32'h000F_00FF, "R5 enable layout");
    step(5'h08, 32'h0001_0001, 1, '0, '0);
    chk(32'(ch_irq_en), 32'h101, "R5 ch0 and ch8 only");

    // R6 / R9
    step(5'h10, 0, 0, 12'h008, '0);
    chk(reg_rdata & 32'hFFFF, 32'h0008, "R6 done sets irq flag");
    chk(32'(irq_out), 0, "R9 flag without enable");
    step(5'h18, 0, 0, '0, 12'h100);
    chk(reg_rdata & 32'hFFFF, 32'h0101, "R6 error sets both flags");
    chk(32'(irq_out), 1, "R9 enabled flag raises irq");

    // R7
    step(5'h18, 32'h0000_0100, 1, 12'h100, '0);
    chk(reg_rdata & 32'hFFFF, 32'h0001, "R7 err cleared, irq kept");
    step(5'h18, 32'h0000_0001, 1, 12'h100, '0);
    chk(reg_rdata & 32'hFFFF, 32'h0001, "R7 set wins over clear");
    step(5'h18, 32'h0000_0001, 1, '0, '0);
    chk(reg_rdata & 32'hFFFF, 32'h0000, "R7 write one clears");
    chk(32'(irq_out), 0, "R9 irq drops after clear");
    step(5'h10, 32'h0000_0000, 1, '0, '0);
    chk(reg_rdata & 32'hFFFF, 32'h0008, "R7 write zero keeps");

    // R8: live state
    ch_state = 24'hE4_1B93;
    step(5'h10, 0, 0, '0, '0);
    chk(reg_rdata >> 16, 32'h1B93, "R8 live state lo");
    step(5'h18, 0, 0, '0, '0);
    chk(reg_rdata >> 16, 32'h00E4, "R8 live state hi");

    // R10: unused offsets
    sv_mode = ch_mode; sv_dir = ch_dir; sv_en = ch_irq_en;
    step(5'h1C, 32'hFFFF_FFFF, 1, '0, '0);
    step(5'h04, 32'hFFFF_FFFF, 1, '0, '0);
    step(5'h14, 32'hFFFF_FFFF, 1, '0, '0);
    step(5'h02, 32'hFFFF_FFFF, 1, '0, '0);
    step(5'h11, 32'hFFFF_FFFF, 1, '0, '0);
    chk(32'(ch_mode), 32'(sv_mode), "R10 mode unchanged");
    chk(32'(ch_dir), 32'(sv_dir), "R10 dir unchanged");
    chk(32'(ch_irq_en), 32'(sv_en), "R10 enable unchanged");
    step(5'h10, 0, 0, '0, '0);
    chk(reg_rdata & 32'hFFFF, 32'h0008, "R10 flags unchanged");
    step(5'h1C, 0, 0, '0, '0); chk(reg_rdata, 0, "R10 offset 1C reads zero");
    step(5'h14, 0, 0, '0, '0); chk(reg_rdata, 0, "R10 offset 14 reads zero");
    step(5'h01, 0, 0, '0, '0); chk(reg_rdata, 0, "R10 unaligned reads zero");

    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: a = 5'h00; 1: a = 5'h0C; 2: a = 5'h08; 3: a = 5'h10;
        4: a = 5'h18; 5: a = 5'h04; 6: a = 5'h14; 7: a = 5'h1C;
        8: a = 5'h10; default: a = 5'($urandom);
      endcase
      @(posedge clk); #2;
      reg_addr  = a;
      reg_wdata = $urandom;
      reg_we    = ($urandom_range(0, 9) < 3);
      ch_done   = NCH'($urandom & $urandom & $urandom);
      ch_err    = NCH'($urandom & $urandom & $urandom & $urandom);
      ch_state  = 2*NCH'($urandom);
    end
    @(posedge clk); #2;
    reg_we = 1'b0; ch_done = '0; ch_err = '0;
    repeat (2) @(posedge clk);
    #6 done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule